// File: doc/BRIEF.md
# Add-Immediate and Jump-and-Link Instruction Decoder

This block is the decode stage of a deliberately minimal 32-bit integer core that runs only two instructions: add-immediate and jump-and-link. It is purely combinational. A 32-bit instruction word goes in, and the control and operand fields that the rest of the core needs come out.

The outputs are the destination and source register indices, a register write enable, and a sign-extended immediate. Three controls steer the datapath:
- the first ALU operand, either the source register value or the program counter;
- the write-back value, either the ALU result or the program counter plus four;
- a program-counter load request.

Any instruction word outside the two supported encodings raises an unsupported flag. It also suppresses every side effect.

Most of the work is in building the immediate. The add-immediate constant is twelve contiguous bits that need sign extension. The jump offset is stored with its bits scrambled and its lowest bit implied, so it has to be reassembled into an even, signed 21-bit offset before it is widened to the data width. The register file, ALU, memories and every other instruction class sit outside this block.

Top module: `addi_jal_decoder`

## Requirements
- R1: When bits 6:0 of the word are 7'b0010011 and bits 14:12 are 3'b000 (add-immediate), the outputs are: `rd_we`=1, `pc_load`=0, `alu_a_sel`=0 (register operand), `wb_sel`=0 (ALU result) and `unsupported`=0.
- R2: For add-immediate, `imm` equals bits 31:20 of the word sign-extended to XLEN bits, with bit 31 copied into every upper bit.
- R3: When bits 6:0 are 7'b1101111 (jump-and-link), the outputs are: `rd_we`=1, `pc_load`=1, `alu_a_sel`=1 (program counter operand), `wb_sel`=1 (PC plus four) and `unsupported`=0, whatever bits 31:7 hold.
- R4: For jump-and-link, `imm` equals the 21-bit value {bit31, bits19:12, bit20, bits30:21, 1'b0} sign-extended to XLEN bits, so `imm[0]` is always 0.
- R5: `rd_idx` always equals bits 11:7 and `rs1_idx` always equals bits 19:15 of the word, whatever the opcode.
- R6: When bits 6:0 are 7'b0010011 but bits 14:12 are not 3'b000, the outputs are: `unsupported`=1, `rd_we`=0, `pc_load`=0, `alu_a_sel`=0, `wb_sel`=0 and `imm`=0.
- R7: Any other value of bits 6:0 gives `unsupported`=1, `rd_we`=0, `pc_load`=0, `alu_a_sel`=0, `wb_sel`=0 and `imm`=0.
- R8: Exactly one of three cases holds for every word: add-immediate (`rd_we`=1 and `pc_load`=0), jump-and-link (`pc_load`=1), or `unsupported`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_i | input | 32 | Instruction word to decode |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Register write enable |
| rs1_idx_o | output | 5 | Source register index |
| imm_o | output | XLEN (32) | Sign-extended immediate |
| alu_a_sel_o | output | 1 | First ALU operand: 0 register, 1 program counter |
| wb_sel_o | output | 1 | Write-back value: 0 ALU result, 1 PC plus four |
| pc_load_o | output | 1 | Program counter loads the ALU result |
| unsupported_o | output | 1 | Word is not a supported instruction |

## Verification
Every result of this decoder is due in the same cycle as its instruction word, because no register lies between `inst_i` and any output. The bench therefore changes the word on the falling clock edge and samples all outputs one nanosecond later. Each sample is taken well inside the half-period, once the combinational paths have settled, and away from either clock edge. The table vectors, the funct3 sweep and the walking-one sweeps of the immediate bits all follow this same drive-then-sample timing.

// File: rtl/addi_jal_dec_pkg.sv
package addi_jal_dec_pkg;

   localparam int OPC_W   = 7;
   localparam int F3_W    = 3;
   localparam int REG_W   = 5;
   localparam int I_IMM_W = 12;
   localparam int J_IMM_W = 21;

   localparam int OPC_LSB = 0;
   localparam int RD_LSB  = 7;
   localparam int F3_LSB  = 12;
   localparam int RS1_LSB = 15;
   localparam int IIM_LSB = 20;

   localparam logic [OPC_W-1:0] OPC_REG_IMM = 7'b0010011;
   localparam logic [OPC_W-1:0] OPC_JMP_LNK = 7'b1101111;
   localparam logic [F3_W-1:0]  F3_ADD      = 3'b000;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_ADDI = 2'd1,
      CLS_JAL  = 2'd2
   } insn_cls_e;

   typedef struct packed {
      logic [OPC_W-1:0]   opcode;
      logic [F3_W-1:0]    funct3;
      logic [REG_W-1:0]   rd;
      logic [REG_W-1:0]   rs1;
      logic [I_IMM_W-1:0] i_raw;
      logic [19:0]        upper;
   } insn_fields_t;

endpackage

// File: rtl/dec_sign_ext.sv
module dec_sign_ext #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  val_i,
   output logic [OUT_W-1:0] val_o
);

   generate
      if (IN_W < 2) begin : g_bad_in
         $error("dec_sign_ext: IN_W must be at least 2");
      end
      if (OUT_W < IN_W) begin : g_bad_out
         $error("dec_sign_ext: OUT_W must not be narrower than IN_W");
      end

      if (OUT_W > IN_W) begin : g_widen
         localparam int PAD_W = OUT_W - IN_W;
         assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
      end else begin : g_pass
         assign val_o = val_i;
      end
   endgenerate

endmodule

// File: rtl/dec_field_split.sv
module dec_field_split
   import addi_jal_dec_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic [ILEN-1:0] inst_i,
   output insn_fields_t    fields_o
);

   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("dec_field_split: only 32-bit instruction words are decoded");
      end
   endgenerate

   always_comb begin
      fields_o.opcode = inst_i[OPC_LSB +: OPC_W];
      fields_o.rd     = inst_i[RD_LSB  +: REG_W];
      fields_o.funct3 = inst_i[F3_LSB  +: F3_W];
      fields_o.rs1    = inst_i[RS1_LSB +: REG_W];
      fields_o.i_raw  = inst_i[IIM_LSB +: I_IMM_W];
      fields_o.upper  = inst_i[31:12];
   end

endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
   import addi_jal_dec_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [F3_W-1:0]  funct3_i,
   output insn_cls_e        cls_o,
   output logic             rd_we_o,
   output logic             pc_load_o,
   output logic             alu_a_sel_o,
   output logic             wb_sel_o,
   output logic             unsupported_o
);

   always_comb begin
      cls_o = CLS_NONE;
      unique case (opcode_i)
         OPC_REG_IMM: if (funct3_i == F3_ADD) cls_o = CLS_ADDI;
         OPC_JMP_LNK: cls_o = CLS_JAL;
         default:     cls_o = CLS_NONE;
      endcase
   end

   always_comb begin
      rd_we_o       = 1'b0;
      pc_load_o     = 1'b0;
      alu_a_sel_o   = 1'b0;
      wb_sel_o      = 1'b0;
      unsupported_o = 1'b0;
      case (cls_o)
         CLS_ADDI: begin
            rd_we_o = 1'b1;
         end
         CLS_JAL: begin
            rd_we_o     = 1'b1;
            pc_load_o   = 1'b1;
            alu_a_sel_o = 1'b1;
            wb_sel_o    = 1'b1;
         end
         default: begin
            unsupported_o = 1'b1;
         end
      endcase
   end

   always_comb begin
      if (opcode_i == OPC_JMP_LNK)
         AST_JAL_ALWAYS_LOADS: assert (pc_load_o && wb_sel_o && alu_a_sel_o)
            else $error("jump word without full jump control"); // R3
      if (opcode_i != OPC_REG_IMM && opcode_i != OPC_JMP_LNK)
         AST_FOREIGN_QUIET: assert (unsupported_o && !rd_we_o && !pc_load_o)
            else $error("foreign opcode produced side effects"); // R7
   end

endmodule

// File: rtl/dec_imm_build.sv
module dec_imm_build
   import addi_jal_dec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  insn_fields_t    fields_i,
   input  insn_cls_e       cls_i,
   output logic [XLEN-1:0] imm_o
);

   logic [J_IMM_W-1:0] j_raw;
   logic [XLEN-1:0]    i_ext;
   logic [XLEN-1:0]    j_ext;

   generate
      if (XLEN < J_IMM_W) begin : g_bad_xlen
         $error("dec_imm_build: XLEN must hold the 21-bit jump offset");
      end
   endgenerate

   // upper holds word bits 31:12; index k here is word bit k+12
   always_comb begin
      j_raw = {fields_i.upper[19],      // word bit 31 -> offset bit 20
               fields_i.upper[7:0],     // word bits 19:12 -> offset 19:12
               fields_i.upper[8],       // word bit 20 -> offset bit 11
               fields_i.upper[18:9],    // word bits 30:21 -> offset 10:1
               1'b0};                   // implied even offset
   end

   dec_sign_ext #(.IN_W(I_IMM_W), .OUT_W(XLEN)) u_i_ext (
      .val_i (fields_i.i_raw),
      .val_o (i_ext)
   );

   dec_sign_ext #(.IN_W(J_IMM_W), .OUT_W(XLEN)) u_j_ext (
      .val_i (j_raw),
      .val_o (j_ext)
   );

   always_comb begin
      case (cls_i)
         CLS_ADDI: imm_o = i_ext;
         CLS_JAL:  imm_o = j_ext;
         default:  imm_o = '0;
      endcase
   end

   always_comb begin
      if (cls_i == CLS_JAL) begin
         AST_JMP_EVEN: assert (imm_o[0] == 1'b0)
            else $error("jump offset is odd"); // R4
         AST_JMP_SIGN: assert (imm_o[XLEN-1] == fields_i.upper[19])
            else $error("jump offset sign lost"); // R4
      end
      if (cls_i == CLS_ADDI)
         AST_ADDI_SIGN: assert (imm_o[XLEN-1] == fields_i.i_raw[I_IMM_W-1])
            else $error("add immediate sign lost"); // R2
      if (cls_i == CLS_NONE)
         AST_NONE_IMM_ZERO: assert (imm_o == '0)
            else $error("immediate on unsupported word"); // R7
   end

endmodule

// File: rtl/addi_jal_decoder.sv
module addi_jal_decoder
   import addi_jal_dec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     inst_i,
   output logic [4:0]      rd_idx_o,
   output logic            rd_we_o,
   output logic [4:0]      rs1_idx_o,
   output logic [XLEN-1:0] imm_o,
   output logic            alu_a_sel_o,
   output logic            wb_sel_o,
   output logic            pc_load_o,
   output logic            unsupported_o
);

   insn_fields_t fields;
   insn_cls_e    cls;

   dec_field_split #(.ILEN(32)) u_split (
      .inst_i   (inst_i),
      .fields_o (fields)
   );

   dec_ctrl u_ctrl (
      .opcode_i      (fields.opcode),
      .funct3_i      (fields.funct3),
      .cls_o         (cls),
      .rd_we_o       (rd_we_o),
      .pc_load_o     (pc_load_o),
      .alu_a_sel_o   (alu_a_sel_o),
      .wb_sel_o      (wb_sel_o),
      .unsupported_o (unsupported_o)
   );

   dec_imm_build #(.XLEN(XLEN)) u_imm (
      .fields_i (fields),
      .cls_i    (cls),
      .imm_o    (imm_o)
   );

   assign rd_idx_o  = fields.rd;
   assign rs1_idx_o = fields.rs1;

   always_comb begin
      AST_ONE_CLASS: assert ($countones({rd_we_o & ~pc_load_o, pc_load_o, unsupported_o}) == 1)
         else $error("decode class not exclusive"); // R8
      if (unsupported_o)
         AST_UNSUP_QUIET: assert (!rd_we_o && !pc_load_o && !wb_sel_o && !alu_a_sel_o)
            else $error("unsupported word has side effects"); // R6
      if (pc_load_o)
         AST_LOAD_IMPLIES_LINK: assert (rd_we_o && wb_sel_o)
            else $error("jump without link write"); // R3
   end

endmodule

// File: tb/addi_jal_decoder_tb.sv
module addi_jal_decoder_tb;

   localparam int NV = 16;
   // class codes: 0 unsupported, 1 add-immediate, 2 jump-and-link
   localparam logic [31:0] VEC_INST [NV] = '{
      32'h00108093, 32'hFFF28513, 32'h800F8F93, 32'h7FF00013,
      32'hFFDFF0EF, 32'h0010006F, 32'h002001EF, 32'h0000106F,
      32'h8000006F, 32'h00109093, 32'h0FF0F093, 32'h002081B3,
      32'h000080E7, 32'hFFDFF0EE, 32'h00000000, 32'hFFFFFFFF
   };
   localparam logic [31:0] VEC_IMM [NV] = '{
      32'h00000001, 32'hFFFFFFFF, 32'hFFFFF800, 32'h000007FF,
      32'hFFFFFFFC, 32'h00000800, 32'h00000002, 32'h00001000,
      32'hFFF00000, 32'h00000000, 32'h00000000, 32'h00000000,
      32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000
   };
   localparam logic [1:0] VEC_CLS [NV] = '{
      2'd1, 2'd1, 2'd1, 2'd1,
      2'd2, 2'd2, 2'd2, 2'd2,
      2'd2, 2'd0, 2'd0, 2'd0,
      2'd0, 2'd0, 2'd0, 2'd0
   };

   logic        clk = 1'b0;
   logic [31:0] inst;
   logic [4:0]  rd_idx, rs1_idx;
   logic [31:0] imm;
   logic        rd_we, alu_a_sel, wb_sel, pc_load, unsupported;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   addi_jal_decoder #(.XLEN(32)) u_dut (
      .inst_i        (inst),
      .rd_idx_o      (rd_idx),
      .rd_we_o       (rd_we),
      .rs1_idx_o     (rs1_idx),
      .imm_o         (imm),
      .alu_a_sel_o   (alu_a_sel),
      .wb_sel_o      (wb_sel),
      .pc_load_o     (pc_load),
      .unsupported_o (unsupported)
   );

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s inst=%h actual=%h expected=%h", req, inst, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] w);
      @(negedge clk);
      inst = w;
      #1;
   endtask

   task automatic check_word(input logic [31:0] w, input logic [1:0] cls, input logic [31:0] eimm);
      string ctl;
      string itag;
      drive(w);
      if (cls == 2'd1) begin
         ctl = "R1 controls"; itag = "R2 imm";
      end else if (cls == 2'd2) begin
         ctl = "R3 controls"; itag = "R4 imm";
      end else if (w[6:0] == 7'b0010011) begin
         ctl = "R6 controls"; itag = "R6 imm";
      end else begin
         ctl = "R7 controls"; itag = "R7 imm";
      end
      cmp("R5 rd index", {27'd0, rd_idx}, {27'd0, w[11:7]});
      cmp("R5 rs1 index", {27'd0, rs1_idx}, {27'd0, w[19:15]});
      cmp(itag, imm, eimm);
      cmp(ctl, {27'd0, rd_we, pc_load, alu_a_sel, wb_sel, unsupported},
          {27'd0, cls != 2'd0, cls == 2'd2, cls == 2'd2, cls == 2'd2, cls == 2'd0});
      cmp("R8 exclusive", {31'd0, ($countones({rd_we & ~pc_load, pc_load, unsupported}) == 1)}, 32'd1);
   endtask

   initial begin
      inst = 32'h0;
      repeat (2) @(negedge clk);
      #1;
      // quiet state with an all-zero word: R7
      cmp("R7 idle quiet", {28'd0, rd_we, pc_load, alu_a_sel, wb_sel}, 32'd0);
      cmp("R7 idle flag", {31'd0, unsupported}, 32'd1);

      for (int k = 0; k < NV; k++)
         check_word(VEC_INST[k], VEC_CLS[k], VEC_IMM[k]);

      // funct3 sweep on the register-immediate opcode: R1 / R6
      for (int f = 0; f < 8; f++) begin
         logic [31:0] w;
         w = {12'h123, 5'd9, f[2:0], 5'd17, 7'b0010011};
         check_word(w, (f == 0) ? 2'd1 : 2'd0, (f == 0) ? 32'h00000123 : 32'h0);
      end

      // walking one through the add immediate: R2
      for (int b = 20; b < 32; b++) begin
         logic [31:0] w;
         w = (32'd1 << b) | 32'h00000013;
         check_word(w, 2'd1, (b == 31) ? 32'hFFFFF800 : (32'd1 << (b - 20)));
      end

      // walking one through the jump offset: R4, and R3 ignoring bits 31:7
      for (int b = 7; b < 32; b++) begin
         logic [31:0] w;
         logic [31:0] e;
         w = (32'd1 << b) | 32'h0000006F;
         if (b == 31)      e = 32'hFFF00000;
         else if (b >= 21) e = 32'd1 << (b - 20);
         else if (b == 20) e = 32'd1 << 11;
         else if (b >= 12) e = 32'd1 << b;
         else              e = 32'd0;
         check_word(w, 2'd2, e);
      end

      // every opcode value except the two supported ones: R7
      for (int o = 0; o < 128; o++) begin
         if (o != 7'h13 && o != 7'h6F) check_word({25'h1ABCDEF, o[6:0]}, 2'd0, 32'h0);
      end

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule